// File: doc/BRIEF.md
# Calendar Time Keeper with BCD/Binary and 12/24-Hour Formats

This block holds the wall-clock time and date of a real-time clock: seconds, minutes, hours, day of week, day of month, month, two-digit year and a century byte. An external one-second strobe advances the count by one second at a time. The carry runs through the minutes, hours, days, months and years. Month lengths follow the Gregorian rules, and the century byte reloads when the year wraps.

Software picks two formats at run time. One selects the data representation, binary or packed BCD. The other selects the hour representation, 24-hour or 12-hour with an afternoon flag. A host write port loads any single field. It is normally used while a freeze input holds the count still. An optional daylight-saving mode moves the clock forward one hour in spring and back one hour in autumn. A single-cycle update-done pulse tells downstream interrupt logic that a new second has been counted.

The count is kept internally in binary. The current formats are applied when a field is read and when a host byte is written.

Top module: `caltime_keeper`

## Requirements
- R1: After reset, with BCD and 24-hour formats selected, the outputs read seconds 00, minutes 00, hours 00, day of week 01, day of month 01, month 01, year 00, century 0x20, and updateDone is 0.
- R2: An accepted strobe adds one second. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 and carry into hours, and hours wrap from 23 and carry into the day. The new values and updateDone=1 appear in the clock cycle after the edge that accepts the strobe, and updateDone lasts one cycle for each accepted strobe.
- R3: Day of month wraps to 1 past the month length. April, June, September and November have 30 days, and the other months except February have 31. February has 29 days when the full year (century*100 + year, with the century read as BCD from its low 7 bits) is divisible by 400, or by 4 and not by 100. Otherwise February has 28 days.
- R4: Month wraps from 12 to 1 and increments the year. When the year wraps from 99 to 00, the low 7 bits of the century byte load 0x20 and bit 7 keeps its previous value.
- R5: With dataBinary=1, every field reads and is written as a plain binary value. With dataBinary=0, every field uses packed BCD (tens in bits 7:4, units in bits 3:0). The century byte is stored and read unconverted. Switching the mode re-renders the stored values.
- R6: With hour24=1, hours read as 0..23. With hour24=0, hour 0 reads as 12, hours 13..23 read as 1..11, and bit 7 is set for hours 12..23. Host writes to the hours field use the same encoding.
- R7: While freeze=1, strobes are discarded and no field changes except by a host write, and updateDone stays 0.
- R8: A host write (wrEn=1) loads wrData into the field selected by wrAddr at the next clock edge, visible in the following cycle. The field codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century.
- R9: When a strobe arrives in a cycle with a host write, the write is applied and the second is counted in the first later cycle without a write, provided freeze is 0.
- R10: Day of week holds 1..7, where 1 is Sunday. It advances whenever the day of month advances, and wraps from 7 to 1.
- R11: With dstEnable=1 at the midnight that starts the first Sunday of April (day 1..7), the step from 01:59:59 on that day goes to 03:00:00.
- R12: With dstEnable=1 at the midnight that starts the last Sunday of October (day 25..31), the first step from 01:59:59 on that day goes to 01:00:00. Any later step from 01:59:59 that day goes to 02:00:00.
- R13: With dstEnable=0, no daylight-saving jump occurs, and the step from 01:59:59 goes to 02:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-second strobe, one cycle wide |
| freeze | input | 1 | Hold the count; host writes remain allowed |
| dataBinary | input | 1 | 1 = binary fields, 0 = packed BCD |
| hour24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| dstEnable | input | 1 | Enable daylight-saving adjustments |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 3 | Field code of the host write |
| wrData | input | 8 | Host write byte in the current formats |
| secOut | output | 8 | Seconds |
| minOut | output | 8 | Minutes |
| hourOut | output | 8 | Hours |
| dowOut | output | 8 | Day of week |
| domOut | output | 8 | Day of month |
| monOut | output | 8 | Month |
| yearOut | output | 8 | Year within the century |
| centOut | output | 8 | Century byte |
| updateDone | output | 1 | One-cycle pulse after a counted second |

## Verification
The counting function is driven from boundary times. These are a plain mid-minute second, 23:59:59 at the end of 30-day, 31-day and February months, a year divisible by 4, a century year whose century digits are or are not divisible by 4, and the 99-to-00 year wrap with the century's top bit set. Together they separate a wrong carry chain from a wrong month-length or leap rule. The same rollovers are repeated in binary and in 12-hour formats, which shows that the encoding sits only at the edges and does not leak into the count. Collisions of strobe and write, strobes under freeze, and daylight-saving days with the enable on or off tell apart dropped, doubled and deferred updates, and show whether the autumn repeat fires only once.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  localparam int unsigned NUM_FIELDS = 8;
  localparam int unsigned FIELD_W    = 7;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_W     = $clog2(NUM_FIELDS);

  localparam logic [FIELD_W-1:0] SEC_LAST   = 7'd59;
  localparam logic [FIELD_W-1:0] MIN_LAST   = 7'd59;
  localparam logic [FIELD_W-1:0] HOUR_LAST  = 7'd23;
  localparam logic [FIELD_W-1:0] DOW_LAST   = 7'd7;
  localparam logic [FIELD_W-1:0] MON_LAST   = 7'd12;
  localparam logic [FIELD_W-1:0] YEAR_LAST  = 7'd99;
  localparam logic [FIELD_W-1:0] SUNDAY     = 7'd1;
  localparam logic [FIELD_W-1:0] DST_HOUR   = 7'd1;
  localparam logic [FIELD_W-1:0] SPRING_MON = 7'd4;
  localparam logic [FIELD_W-1:0] FALL_MON   = 7'd10;
  localparam logic [FIELD_W-1:0] CENT_ROLL  = 7'h20;

  typedef enum logic [ADDR_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DOW  = 3'd3,
    F_DOM  = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6,
    F_CENT = 3'd7
  } fieldSel_e;

  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] load;
  } calStrobe_t;

  // Render a binary field value (0..99) as binary or packed BCD.
  function automatic logic [BYTE_W-1:0] encField(input logic [FIELD_W-1:0] v,
                                                 input logic bin);
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] r;
    q = {1'b0, v} / 8'd10;
    r = {1'b0, v} % 8'd10;
    return bin ? {1'b0, v} : BYTE_W'((q << 4) | r);
  endfunction

  // Turn a binary or packed-BCD byte back into a binary field value.
  function automatic logic [FIELD_W-1:0] decField(input logic [BYTE_W-1:0] d,
                                                  input logic bin);
    logic [BYTE_W-1:0] b;
    b = ({4'd0, d[7:4]} * 8'd10) + {4'd0, d[3:0]};
    return bin ? d[FIELD_W-1:0] : b[FIELD_W-1:0];
  endfunction

endpackage

// File: rtl/caltime_ctrl.sv
module caltime_ctrl
  import caltime_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              freeze,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output calStrobe_t        stb
);

  logic pendingQ;
  logic wantTick;

  assign wantTick = (secTick || pendingQ) && !freeze;

  always_comb begin
    stb.advance = wantTick && !wrEn;
    stb.load    = '0;
    if (wrEn) stb.load[wrAddr] = 1'b1;
  end

  // A second that collides with a host write is held for one slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingQ <= 1'b0;
    else       pendingQ <= wantTick && wrEn;
  end

  AST_COLLIDE_DEFER: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && wrEn && !freeze) |=> (stb.advance || wrEn || freeze)); // R9

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.load) && (stb.load == '0 || !stb.advance)); // R8

endmodule

// File: rtl/caltime_datapath.sv
module caltime_datapath
  import caltime_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        stb,
  input  logic              dataBinary,
  input  logic              hour24,
  input  logic              dstEnable,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] secOut,
  output logic [BYTE_W-1:0] minOut,
  output logic [BYTE_W-1:0] hourOut,
  output logic [BYTE_W-1:0] dowOut,
  output logic [BYTE_W-1:0] domOut,
  output logic [BYTE_W-1:0] monOut,
  output logic [BYTE_W-1:0] yearOut,
  output logic [BYTE_W-1:0] centOut,
  output logic              updateDone
);

  logic [FIELD_W-1:0] secQ, minQ, hourQ, dowQ, domQ, monQ, yearQ;
  logic [BYTE_W-1:0]  centQ;
  logic               armSpringQ, armFallQ, doneQ;

  // ---------------- host write decoding ----------------
  logic [FIELD_W-1:0] wrVal, wrVal12, wrHour;
  always_comb begin
    wrVal   = decField(wrData, dataBinary);
    wrVal12 = decField({1'b0, wrData[6:0]}, dataBinary);
    if (hour24) begin
      wrHour = wrVal;
    end else begin
      wrHour = (wrVal12 >= 7'd12) ? (wrVal12 - 7'd12) : wrVal12;
      if (wrData[7]) wrHour = wrHour + 7'd12;
    end
  end

  // ---------------- calendar rules ----------------
  logic [FIELD_W-1:0] centBin, monthLen;
  logic               isLeap;
  always_comb begin
    centBin = decField({1'b0, centQ[6:0]}, 1'b0);
    isLeap  = (yearQ[1:0] == 2'b00) &&
              ((yearQ != '0) || (centBin[1:0] == 2'b00));
    case (monQ)
      7'd2:                         monthLen = isLeap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:      monthLen = 7'd30;
      default:                      monthLen = 7'd31;
    endcase
  end

  // ---------------- one-second step ----------------
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap, yearWrap;
  logic atDstHour, springJump, fallBack;
  logic [FIELD_W-1:0] secNxt, minNxt, hourNxt, dowNxt, domNxt, monNxt, yearNxt;
  logic [BYTE_W-1:0]  centNxt;
  logic               armSpringNxt, armFallNxt;

  always_comb begin
    secWrap    = secQ >= SEC_LAST;
    minWrap    = secWrap && (minQ >= MIN_LAST);
    atDstHour  = dstEnable && (hourQ == DST_HOUR) && minWrap;
    springJump = atDstHour && armSpringQ;
    fallBack   = atDstHour && armFallQ && !armSpringQ;
    hourWrap   = minWrap && (hourQ >= HOUR_LAST);
    dayWrap    = hourWrap && (domQ >= monthLen);
    monWrap    = dayWrap && (monQ >= MON_LAST);
    yearWrap   = monWrap && (yearQ >= YEAR_LAST);

    secNxt = secWrap ? '0 : secQ + 7'd1;

    minNxt = minQ;
    if (secWrap) minNxt = (minQ >= MIN_LAST) ? '0 : minQ + 7'd1;

    hourNxt = hourQ;
    if (springJump)    hourNxt = DST_HOUR + 7'd2;
    else if (fallBack) hourNxt = DST_HOUR;
    else if (hourWrap) hourNxt = '0;
    else if (minWrap)  hourNxt = hourQ + 7'd1;

    dowNxt = dowQ;
    domNxt = domQ;
    if (hourWrap) begin
      dowNxt = (dowQ >= DOW_LAST) ? SUNDAY : dowQ + 7'd1;
      domNxt = dayWrap ? 7'd1 : domQ + 7'd1;
    end

    monNxt = monQ;
    if (monWrap)      monNxt = 7'd1;
    else if (dayWrap) monNxt = monQ + 7'd1;

    yearNxt = yearQ;
    if (yearWrap)     yearNxt = '0;
    else if (monWrap) yearNxt = yearQ + 7'd1;

    centNxt = yearWrap ? {centQ[7], CENT_ROLL} : centQ;

    // The Sunday tests run when the day changes, on the new date.
    armSpringNxt = armSpringQ;
    armFallNxt   = armFallQ;
    if (hourWrap) begin
      armSpringNxt = dstEnable && (monNxt == SPRING_MON) &&
                     (dowNxt == SUNDAY) && (domNxt <= 7'd7);
      armFallNxt   = dstEnable && (monNxt == FALL_MON) &&
                     (dowNxt == SUNDAY) && (domNxt >= 7'd25);
    end else if (fallBack) begin
      armFallNxt   = 1'b0;
    end
  end

  // ---------------- state ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ       <= '0;
      minQ       <= '0;
      hourQ      <= '0;
      dowQ       <= SUNDAY;
      domQ       <= 7'd1;
      monQ       <= 7'd1;
      yearQ      <= '0;
      centQ      <= {1'b0, CENT_ROLL};
      armSpringQ <= 1'b0;
      armFallQ   <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= stb.advance;

      if (stb.load[F_SEC])       secQ <= wrVal;
      else if (stb.advance)      secQ <= secNxt;

      if (stb.load[F_MIN])       minQ <= wrVal;
      else if (stb.advance)      minQ <= minNxt;

      if (stb.load[F_HOUR])      hourQ <= wrHour;
      else if (stb.advance)      hourQ <= hourNxt;

      if (stb.load[F_DOW])       dowQ <= wrVal;
      else if (stb.advance)      dowQ <= dowNxt;

      if (stb.load[F_DOM])       domQ <= wrVal;
      else if (stb.advance)      domQ <= domNxt;

      if (stb.load[F_MON])       monQ <= wrVal;
      else if (stb.advance)      monQ <= monNxt;

      if (stb.load[F_YEAR])      yearQ <= wrVal;
      else if (stb.advance)      yearQ <= yearNxt;

      if (stb.load[F_CENT])      centQ <= wrData;
      else if (stb.advance)      centQ <= centNxt;

      if (stb.advance) begin
        armSpringQ <= armSpringNxt;
        armFallQ   <= armFallNxt;
      end
    end
  end

  // ---------------- output rendering ----------------
  logic [FIELD_W-1:0] hour12;
  logic [BYTE_W-1:0]  hour12Enc;
  always_comb begin
    if (hourQ == '0)         hour12 = 7'd12;
    else if (hourQ > 7'd12)  hour12 = hourQ - 7'd12;
    else                     hour12 = hourQ;
    hour12Enc = encField(hour12, dataBinary);
  end

  assign secOut     = encField(secQ, dataBinary);
  assign minOut     = encField(minQ, dataBinary);
  assign hourOut    = hour24 ? encField(hourQ, dataBinary)
                             : {(hourQ >= 7'd12), hour12Enc[6:0]};
  assign dowOut     = encField(dowQ, dataBinary);
  assign domOut     = encField(domQ, dataBinary);
  assign monOut     = encField(monQ, dataBinary);
  assign yearOut    = encField(yearQ, dataBinary);
  assign centOut    = centQ;
  assign updateDone = doneQ;

  // ---------------- assertions ----------------
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.load[F_SEC] && (secQ < SEC_LAST)) |=>
      (secQ == $past(secQ) + 7'd1) && updateDone); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && (stb.load == '0)) |=>
      ($stable({secQ, minQ, hourQ, dowQ, domQ, monQ, yearQ, centQ}) && !updateDone)); // R7

  AST_CENT_ROLL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && yearWrap) |=>
      (centQ[6:0] == CENT_ROLL) && (centQ[7] == $past(centQ[7])) && (yearQ == '0)); // R4

  AST_DOW_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && hourWrap && (dowQ == DOW_LAST)) |=> (dowQ == SUNDAY)); // R10

endmodule

// File: rtl/caltime_keeper.sv
module caltime_keeper
  import caltime_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              freeze,
  input  logic              dataBinary,
  input  logic              hour24,
  input  logic              dstEnable,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] secOut,
  output logic [BYTE_W-1:0] minOut,
  output logic [BYTE_W-1:0] hourOut,
  output logic [BYTE_W-1:0] dowOut,
  output logic [BYTE_W-1:0] domOut,
  output logic [BYTE_W-1:0] monOut,
  output logic [BYTE_W-1:0] yearOut,
  output logic [BYTE_W-1:0] centOut,
  output logic              updateDone
);

  calStrobe_t stb;

  caltime_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .secTick (secTick),
    .freeze  (freeze),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .stb     (stb)
  );

  caltime_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .dataBinary (dataBinary),
    .hour24     (hour24),
    .dstEnable  (dstEnable),
    .wrData     (wrData),
    .secOut     (secOut),
    .minOut     (minOut),
    .hourOut    (hourOut),
    .dowOut     (dowOut),
    .domOut     (domOut),
    .monOut     (monOut),
    .yearOut    (yearOut),
    .centOut    (centOut),
    .updateDone (updateDone)
  );

endmodule

// File: tb/caltime_keeper_bench.sv
module caltime_keeper_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0, freeze = 1'b0, dataBinary = 1'b0;
  logic       hour24 = 1'b1, dstEnable = 1'b0, wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] secOut, minOut, hourOut, dowOut, domOut, monOut, yearOut, centOut;
  logic       updateDone;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  caltime_keeper u_caltime_keeper (
    .clk(clk), .rstN(rstN), .secTick(secTick), .freeze(freeze),
    .dataBinary(dataBinary), .hour24(hour24), .dstEnable(dstEnable),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .dowOut(dowOut),
    .domOut(domOut), .monOut(monOut), .yearOut(yearOut), .centOut(centOut),
    .updateDone(updateDone)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tickOnce();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic setAll(input logic [7:0] c, y, mo, d, w, h, mi, s);
    wr(3'd7, c); wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d);
    wr(3'd3, w); wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  task automatic t_reset();
    chk("R1 sec", secOut, 8'h00);   chk("R1 min", minOut, 8'h00);
    chk("R1 hour", hourOut, 8'h00); chk("R1 dow", dowOut, 8'h01);
    chk("R1 dom", domOut, 8'h01);   chk("R1 mon", monOut, 8'h01);
    chk("R1 year", yearOut, 8'h00); chk("R1 cent", centOut, 8'h20);
    chk("R1 done", {7'd0, updateDone}, 8'h00);
  endtask

  task automatic t_basic();
    setAll(8'h20, 8'h23, 8'h06, 8'h15, 8'h05, 8'h12, 8'h59, 8'h58);
    chk("R8 sec loaded", secOut, 8'h58);
    chk("R8 min loaded", minOut, 8'h59);
    tickOnce();
    chk("R2 sec step", secOut, 8'h59);
    chk("R2 done pulse", {7'd0, updateDone}, 8'h01);
    @(negedge clk);
    chk("R2 done one cycle", {7'd0, updateDone}, 8'h00);
    tickOnce();
    chk("R2 sec wrap", secOut, 8'h00);
    chk("R2 min wrap", minOut, 8'h00);
    chk("R2 hour carry", hourOut, 8'h13);
    chk("R2 dom same", domOut, 8'h15);
  endtask

  task automatic dayStep(input string tag, input logic [7:0] c, y, mo, d,
                         input logic [7:0] expDom, expMon);
    setAll(c, y, mo, d, 8'h03, 8'h23, 8'h59, 8'h59);
    tickOnce();
    chk({tag, " dom"}, domOut, expDom);
    chk({tag, " mon"}, monOut, expMon);
  endtask

  task automatic t_months();
    dayStep("R3 leap 2024 feb28", 8'h20, 8'h24, 8'h02, 8'h28, 8'h29, 8'h02);
    dayStep("R3 leap 2024 feb29", 8'h20, 8'h24, 8'h02, 8'h29, 8'h01, 8'h03);
    dayStep("R3 2023 feb28", 8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h03);
    dayStep("R3 1900 feb28", 8'h19, 8'h00, 8'h02, 8'h28, 8'h01, 8'h03);
    dayStep("R3 2000 feb28", 8'h20, 8'h00, 8'h02, 8'h28, 8'h29, 8'h02);
    dayStep("R3 apr30", 8'h20, 8'h23, 8'h04, 8'h30, 8'h01, 8'h05);
    dayStep("R3 jan30", 8'h20, 8'h23, 8'h01, 8'h30, 8'h31, 8'h01);
    chk("R2 hour wrap", hourOut, 8'h00);
  endtask

  task automatic t_dow();
    setAll(8'h20, 8'h23, 8'h01, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    tickOnce();
    chk("R10 dow 7 to 1", dowOut, 8'h01);
    chk("R10 dom", domOut, 8'h01);
    chk("R10 mon", monOut, 8'h02);
    tickOnce();
    chk("R10 dow same within day", dowOut, 8'h01);
  endtask

  task automatic t_year();
    setAll(8'h99, 8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    tickOnce();
    chk("R4 year wrap", yearOut, 8'h00);
    chk("R4 month wrap", monOut, 8'h01);
    chk("R4 century keeps msb", centOut, 8'hA0);
    setAll(8'h19, 8'h42, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    tickOnce();
    chk("R4 year inc", yearOut, 8'h43);
    chk("R4 century untouched", centOut, 8'h19);
    setAll(8'h19, 8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    tickOnce();
    chk("R4 century 19 to 20", centOut, 8'h20);
  endtask

  task automatic t_binary();
    @(negedge clk) dataBinary = 1'b1;
    wr(3'd2, 8'd23); wr(3'd1, 8'd59); wr(3'd0, 8'd58);
    tickOnce();
    chk("R5 bin sec", secOut, 8'd59);
    chk("R5 bin hour", hourOut, 8'd23);
    tickOnce();
    chk("R5 bin sec wrap", secOut, 8'd0);
    chk("R5 bin hour wrap", hourOut, 8'd0);
    wr(3'd0, 8'd45);
    chk("R5 bin write", secOut, 8'h2D);
    @(negedge clk) dataBinary = 1'b0;
    @(negedge clk);
    chk("R5 rerender bcd", secOut, 8'h45);
  endtask

  task automatic t_hour12();
    @(negedge clk) hour24 = 1'b0;
    wr(3'd2, 8'h12);
    chk("R6 12AM reads 12", hourOut, 8'h12);
    @(negedge clk) hour24 = 1'b1;
    @(negedge clk);
    chk("R6 12AM is hour 0", hourOut, 8'h00);
    @(negedge clk) hour24 = 1'b0;
    wr(3'd2, 8'h91); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tickOnce();
    chk("R6 11PM to 12AM", hourOut, 8'h12);
    wr(3'd2, 8'h11); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tickOnce();
    chk("R6 11AM to 12PM", hourOut, 8'h92);
    @(negedge clk) hour24 = 1'b1;
    @(negedge clk);
    chk("R6 12PM is hour 12", hourOut, 8'h12);
  endtask

  task automatic t_freeze();
    wr(3'd0, 8'h20);
    @(negedge clk) freeze = 1'b1;
    tickOnce();
    chk("R7 frozen sec", secOut, 8'h20);
    chk("R7 frozen done", {7'd0, updateDone}, 8'h00);
    wr(3'd0, 8'h30);
    chk("R7 write while frozen", secOut, 8'h30);
    @(negedge clk);
    chk("R7 no late step", secOut, 8'h30);
    freeze = 1'b0;
    tickOnce();
    chk("R7 counts after release", secOut, 8'h31);
  endtask

  task automatic t_collide();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h10; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    chk("R9 write wins", secOut, 8'h10);
    chk("R9 no done yet", {7'd0, updateDone}, 8'h00);
    @(negedge clk);
    chk("R9 deferred step", secOut, 8'h11);
    chk("R9 deferred done", {7'd0, updateDone}, 8'h01);
    @(negedge clk);
    chk("R9 single step", secOut, 8'h11);
  endtask

  task automatic t_dst();
    @(negedge clk) dstEnable = 1'b1;
    setAll(8'h20, 8'h24, 8'h04, 8'h03, 8'h07, 8'h23, 8'h59, 8'h59);
    tickOnce();
    chk("R11 sunday", dowOut, 8'h01);
    wr(3'd2, 8'h01); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tickOnce();
    chk("R11 spring hour", hourOut, 8'h03);
    chk("R11 spring min", minOut, 8'h00);
    setAll(8'h20, 8'h24, 8'h10, 8'h30, 8'h07, 8'h23, 8'h59, 8'h59);
    tickOnce();
    wr(3'd2, 8'h01); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tickOnce();
    chk("R12 fall back hour", hourOut, 8'h01);
    chk("R12 fall back sec", secOut, 8'h00);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tickOnce();
    chk("R12 only once", hourOut, 8'h02);
    @(negedge clk) dstEnable = 1'b0;
    setAll(8'h20, 8'h24, 8'h04, 8'h03, 8'h07, 8'h23, 8'h59, 8'h59);
    tickOnce();
    wr(3'd2, 8'h01); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tickOnce();
    chk("R13 disabled no jump", hourOut, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_months();
    t_dow();
    t_year();
    t_binary();
    t_hour12();
    t_freeze();
    t_collide();
    t_dst();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule